// File: doc/BRIEF.md
# Double-Buffered Serial Data Register

This block is the byte-wide data path of a two-wire serial controller. It contains a shift register that exchanges one bit with the bus on every shift strobe, a transmit holding buffer that the host fills ahead of time, and a receive holding buffer that keeps the last completed incoming byte for the host. Bytes move between these three registers automatically as frames complete and as start conditions are seen, so the host only writes and reads a single data location and watches two flags.

The host data location is shared with an 8-bit address register. A select input chooses which of the two a host access reaches. Bus timing, start and stop generation, arbitration and address matching are handled by neighbouring logic. That logic supplies the shift strobes, the serial input bit and the start-detected pulse, and it reads back the serial output bit and the frame-done pulse.

Top module: `ser_data_reg`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets `tx_empty` to 1. It clears `rx_full`, the shift register, both holding buffers and the address register, so `sda_out` and `host_rdata` read 0. It leaves the shift register idle, meaning the next transmit write goes straight to it.
- R2: `sda_out` always shows bit 7 of the shift register. Each clock with `shift_en` high shifts the register left by one and takes `sda_in` into bit 0, so a byte leaves most significant bit first.
- R3: A frame completes on the 8th shift strobe counted from reset or from the last start. `frame_done` is high for exactly the one cycle after that strobe's edge.
- R4: With `dir_tx`=1, a completing frame copies pending holding data into the shift register, and `tx_empty` returns to 1.
- R5: With `dir_tx`=1 and `tx_empty`=1 at frame completion, the shift register goes idle. The next data write (`sel_data`=1) is loaded straight into the shift register, and `tx_empty` stays 1.
- R6: A transmit data write made while the shift register is not idle goes into the holding buffer and drives `tx_empty` to 0.
- R7: With `dir_tx`=0, the holding buffer is never copied into the shift register. Host data writes are ignored: they change no flag and are never sent.
- R8: A `start_det` pulse discards any pending holding byte, sets `tx_empty` to 1, restarts the bit count and makes the shift register idle. A data write in the same cycle as the pulse is discarded.
- R9: With `dir_tx`=0, a completing frame copies the fully shifted byte into the receive buffer and sets `rx_full`. `host_rdata` (with `sel_data`=1) shows a new byte only from that point on.
- R10: A host read of the data location (`host_rd` with `sel_data`=1) clears `rx_full`. A read in the same cycle as a receive load leaves `rx_full` set.
- R11: With `sel_data`=0, writes go to the address register, shown on `addr_q` and on `host_rdata`. The data path and its flags are left untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_data | input | 1 | 1: host accesses data path, 0: address register |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Receive buffer or address register |
| dir_tx | input | 1 | 1 transmit, 0 receive |
| tx_empty | output | 1 | Transmit holding buffer empty |
| rx_full | output | 1 | Receive buffer holds an unread byte |
| start_det | input | 1 | Start condition detected pulse |
| shift_en | input | 1 | Shift strobe |
| sda_in | input | 1 | Serial bit in |
| sda_out | output | 1 | Serial bit out |
| frame_done | output | 1 | One-cycle pulse after a completed frame |
| addr_q | output | 8 | Address register contents |

## Verification
The bench checks the hand-off when a frame ends with and without pending data. A design that reloaded from an empty holding buffer would resend a stale byte, and one that never went idle would drop the next write. It sends bytes in receive direction while a transmit byte is still pending; a design that copied in that direction would shift that byte out instead of the received one. It also checks a start pulse in the middle of a frame and a write in the same cycle as the start, where a wrong bit count or a kept write would corrupt the next frame. Finally it checks a read that lands on the same edge as a receive load, where a wrong priority would lose the full flag.

// File: rtl/ser_data_reg.sv
module ser_data_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sel_data,
  input  logic         host_wr,
  input  logic         host_rd,
  input  logic [W-1:0] host_wdata,
  output logic [W-1:0] host_rdata,
  input  logic         dir_tx,
  output logic         tx_empty,
  output logic         rx_full,
  input  logic         start_det,
  input  logic         shift_en,
  input  logic         sda_in,
  output logic         sda_out,
  output logic         frame_done,
  output logic [W-1:0] addr_q
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  sh_q, txb_q, rxb_q;
  logic [CW-1:0] cnt_q;
  logic          idle_q;

  wire         frame_end = shift_en && (cnt_q == LAST);
  wire         data_wr   = host_wr && sel_data && dir_tx && !start_det;
  wire         direct    = idle_q || (frame_end && tx_empty);
  wire [W-1:0] shifted   = {sh_q[W-2:0], sda_in};

  assign sda_out    = sh_q[W-1];
  assign host_rdata = sel_data ? rxb_q : addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q       <= '0;
      txb_q      <= '0;
      rxb_q      <= '0;
      addr_q     <= '0;
      cnt_q      <= '0;
      idle_q     <= 1'b1;
      tx_empty   <= 1'b1;
      rx_full    <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= frame_end;
      if (host_rd && sel_data)
        rx_full <= 1'b0;
      if (shift_en) begin
        sh_q  <= shifted;
        cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end
      if (frame_end) begin
        if (!dir_tx) begin
          rxb_q   <= shifted;
          rx_full <= 1'b1;
        end else if (!tx_empty) begin
          sh_q     <= txb_q;
          tx_empty <= 1'b1;
        end else begin
          idle_q <= 1'b1;
        end
      end
      if (data_wr) begin
        if (direct) begin
          sh_q   <= host_wdata;
          idle_q <= 1'b0;
        end else begin
          txb_q    <= host_wdata;
          tx_empty <= 1'b0;
        end
      end
      if (start_det) begin
        txb_q    <= '0;
        tx_empty <= 1'b1;
        idle_q   <= 1'b1;
        cnt_q    <= '0;
      end
      if (host_wr && !sel_data)
        addr_q <= host_wdata;
    end
  end
endmodule

module ser_data_reg_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         sel_data,
  input logic         host_wr,
  input logic         host_rd,
  input logic [W-1:0] host_wdata,
  input logic [W-1:0] host_rdata,
  input logic         dir_tx,
  input logic         tx_empty,
  input logic         rx_full,
  input logic         start_det,
  input logic         shift_en,
  input logic         sda_in,
  input logic         sda_out,
  input logic         frame_done,
  input logic [W-1:0] addr_q
);
  AST_EMPTY_AFTER_START: assert property (@(posedge clk) disable iff (rst) start_det |=> tx_empty); // R8
  AST_EMPTY_FALL_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst) $fell(tx_empty) |-> $past(host_wr && sel_data && dir_tx)); // R6
  AST_RX_WRITE_NO_FLAG: assert property (@(posedge clk) disable iff (rst) (host_wr && sel_data && !dir_tx && !start_det) |=> $stable(tx_empty)); // R7
  AST_FULL_ONLY_AT_FRAME: assert property (@(posedge clk) disable iff (rst) $rose(rx_full) |-> frame_done); // R9
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) frame_done |=> !frame_done); // R3
  AST_ADDR_WRITE: assert property (@(posedge clk) disable iff (rst) (host_wr && !sel_data) |=> (addr_q == $past(host_wdata))); // R11
endmodule

bind ser_data_reg ser_data_reg_chk #(.W(W)) u_chk (.*);

// File: tb/test_ser_data_reg.sv
module test_ser_data_reg;
  logic clk = 1'b0;
  logic rst = 1'b1, sel_data = 1'b1, host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata, addr_q;
  logic dir_tx = 1'b1, start_det = 1'b0, shift_en = 1'b0, sda_in = 1'b0;
  logic tx_empty, rx_full, sda_out, frame_done;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  ser_data_reg i_ser_data_reg (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit same(input int a, input int b);
    return a == b;
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic wr(input logic [7:0] d);
    host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd();
    host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic pulse_start();
    start_det = 1'b1;
    @(negedge clk);
    start_det = 1'b0;
  endtask

  task automatic strobes(input logic [7:0] din, input int n, output logic [7:0] got, output bit early);
    got = '0; early = 1'b0;
    for (int i = 0; i < n; i++) begin
      got[7-i] = sda_out;
      sda_in = din[7-i]; shift_en = 1'b1;
      @(negedge clk);
      shift_en = 1'b0;
      if (i < 7 && frame_done) early = 1'b1;
    end
  endtask

  task automatic frame(input logic [7:0] din, output logic [7:0] got);
    bit early;
    strobes(din, 8, got, early);
    chk(!early && frame_done, "R3", frame_done, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] a, b, c, d, e, got;
    bit early;
    void'($urandom(32'd20240611));
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk(tx_empty === 1'b1, "R1", tx_empty, 1);
    chk(rx_full === 1'b0, "R1", rx_full, 0);
    chk(sda_out === 1'b0, "R1", sda_out, 0);
    chk(host_rdata === 8'h00, "R1", host_rdata, 0);
    sel_data = 1'b0; #1;
    chk(host_rdata === 8'h00, "R1", host_rdata, 0);
    sel_data = 1'b1;

    a = 8'hA5; b = 8'h3C; c = 8'hE1;
    wr(a);
    chk(tx_empty === 1'b1, "R1 R5 direct load", tx_empty, 1);
    chk(sda_out === a[7], "R2", sda_out, a[7]);
    wr(b);
    chk(tx_empty === 1'b0, "R6", tx_empty, 0);
    frame(8'h00, got);
    chk(same(got, a), "R2", got, a);
    chk(tx_empty === 1'b1, "R4", tx_empty, 1);
    @(negedge clk);
    chk(frame_done === 1'b0, "R3", frame_done, 0);
    frame(8'hFF, got);
    chk(same(got, b), "R4", got, b);
    wr(c);
    chk(tx_empty === 1'b1, "R5", tx_empty, 1);
    frame(8'h00, got);
    chk(same(got, c), "R5", got, c);

    for (int k = 0; k < 30; k++) begin
      a = 8'($urandom); b = 8'($urandom);
      wr(a); wr(b);
      chk(tx_empty === 1'b0, "R6", tx_empty, 0);
      frame(8'($urandom), got);
      chk(same(got, a), "R5", got, a);
      frame(8'($urandom), got);
      chk(same(got, b), "R4", got, b);
    end

    pulse_start();
    a = 8'h81; b = 8'h7E; d = 8'hC3; e = 8'h5A;
    wr(a); wr(b);
    dir_tx = 1'b0;
    frame(d, got);
    chk(same(got, a), "R2", got, a);
    chk(rx_full === 1'b1, "R9", rx_full, 1);
    chk(same(host_rdata, d), "R9", host_rdata, d);
    chk(tx_empty === 1'b0, "R7 no copy", tx_empty, 0);
    frame(e, got);
    chk(same(got, d), "R7 no copy", got, d);
    chk(same(host_rdata, e), "R9", host_rdata, e);
    rd();
    chk(rx_full === 1'b0, "R10", rx_full, 0);
    wr(8'h99);
    chk(tx_empty === 1'b0, "R7 write ignored", tx_empty, 0);
    frame(8'h12, got);
    chk(same(got, e), "R7 write ignored", got, e);
    rd();
    strobes(8'h6D, 7, got, early);
    chk(same(host_rdata, 8'h12) && !rx_full, "R9 not before frame end", host_rdata, 8'h12);
    host_rd = 1'b1; sda_in = 1'b1; shift_en = 1'b1;
    @(negedge clk);
    host_rd = 1'b0; shift_en = 1'b0;
    chk(rx_full === 1'b1, "R10 read vs load", rx_full, 1);
    chk(same(host_rdata, 8'h6D), "R9", host_rdata, 8'h6D);
    rd();

    for (int k = 0; k < 20; k++) begin
      d = 8'($urandom);
      frame(d, got);
      chk(same(host_rdata, d) && rx_full, "R9", host_rdata, d);
      rd();
      chk(rx_full === 1'b0, "R10", rx_full, 0);
    end

    dir_tx = 1'b1;
    pulse_start();
    a = 8'h11; b = 8'h22; c = 8'hB4;
    wr(a); wr(b);
    pulse_start();
    chk(tx_empty === 1'b1, "R8", tx_empty, 1);
    wr(c);
    chk(tx_empty === 1'b1, "R8 idle after start", tx_empty, 1);
    frame(8'h00, got);
    chk(same(got, c), "R8", got, c);
    wr(a);
    strobes(8'h00, 3, got, early);
    pulse_start();
    c = 8'h4B;
    wr(c);
    frame(8'h00, got);
    chk(same(got, c), "R8 count restart", got, c);
    host_wdata = 8'hF0; host_wr = 1'b1; start_det = 1'b1;
    @(negedge clk);
    host_wr = 1'b0; start_det = 1'b0;
    chk(tx_empty === 1'b1, "R8 same-cycle write", tx_empty, 1);
    wr(8'h0F);
    frame(8'h00, got);
    chk(same(got, 8'h0F), "R8 same-cycle write", got, 8'h0F);

    wr(8'h55);
    sel_data = 1'b0;
    wr(8'h5A);
    #1;
    chk(same(addr_q, 8'h5A), "R11", addr_q, 8'h5A);
    chk(same(host_rdata, 8'h5A), "R11", host_rdata, 8'h5A);
    chk(tx_empty === 1'b1, "R11 flags untouched", tx_empty, 1);
    sel_data = 1'b1;
    frame(8'h00, got);
    chk(same(got, 8'h55), "R11 data path untouched", got, 8'h55);

    finish_run();
  end
endmodule